// File: doc/BRIEF.md
# NAND Flash Window Bridge

This block connects an 8-bit NAND flash device to a simple CPU-side request/acknowledge bus. Software reaches the flash through one mapped address window. The low address bits of each byte access inside that window select which flash control lines are raised for that access: address latch, command latch, chip select, spare-area select and write protect. A command, an address byte or a data byte is therefore sent just by writing to the matching offset. A register region at the bottom of the address space holds four registers. The window-select register gives the window base, an ignore mask and an enable. The control register holds the mode, muxing, polarity and routing bits. The timing register holds the strobe wait, hold, recovery, clock multiplier and setup fields. The status register reports ready/busy and a sticky completion flag.

One sequencer runs each strobed transfer through named states. ST_IDLE waits for a window access. The start transition goes to ST_SETUP when setup is enabled, and to ST_STROBE otherwise. ST_SETUP moves to ST_STROBE. ST_STROBE holds WE# or RE# low. It moves to ST_HOLD when the hold count is non-zero, or else to ST_RECOV when the recovery count is non-zero. If both counts are zero it finishes. ST_HOLD moves to ST_RECOV, or finishes when the recovery count is zero. ST_RECOV drives precharge and then finishes. For a write, finishing goes to ST_IDLE. For a read, finishing goes to ST_RDACK, which hands the sampled byte to the CPU and returns to ST_IDLE. Window writes are posted: they are acknowledged at the start transition. Software then polls the completion flag.

Top module: `nand_window_bridge`

## Requirements
- R1: The window-select register (offset 0x24) holds the base in bits 23:12, the ignore mask in bits 7:4 (mask value m ignores base bits 12 to 12+m-1) and the enable in bit 0. An access that falls in neither the register region (address bits 23:8 all zero) nor the enabled window is acknowledged at once and reads 0. It causes no activity on the flash pins.
- R2: Inside the window, for the whole setup, strobe and hold phases, address bit 2 raises ALE, bit 3 raises CLE, bit 4 raises chip select, bit 5 raises spare select and bit 6 raises write protect. All of these lines are low in every other phase.
- R3: Control bits 4, 5, 6 and 7 make the chip-select, spare-select, write-protect and precharge pins active-low when set. The reset value 0 makes all four pins active-high.
- R4: Control bit 10 routes the chip select to nf_cs[1] instead of nf_cs[0]. Control bit 8 makes status bit 0 follow nf_rb[1] instead of nf_rb[0].
- R5: When control bit 0 (NAND mode) is clear, window accesses are treated as in R1. When control bit 20 (chip enable) is clear, chip select is never asserted. When control bit 1 (chip-select mux) is clear, chip select is asserted on every window access whatever the value of address bit 4.
- R6: The strobe lasts max(W,1) times U clock cycles. W is timing bits 9:8 for writes and bits 7:6 for reads. U is 1, 4, 8 or 16 for multiplier field bits 1:0 equal to 0, 1, 2 or 3.
- R7: The phases run in a fixed order: setup for U cycles if timing bit 22 is set, then strobe, then hold for (bits 5:4) times U cycles, then recovery for (bits 3:2) times U cycles. The precharge pin is active only during recovery.
- R8: Status bit 3 (register at 0xB4) clears when a strobed access starts. It sets when that access finishes its last phase, and it reads 1 after reset.
- R9: nf_dq_oe is high only during a write strobe, and nf_dq_o then carries bits 7:0 of the written data.
- R10: A window read samples nf_dq_i at the rising edge of RE#. It is acknowledged after recovery, with the byte in cpu_rdata[7:0] and the upper bits zero.
- R11: Register accesses are acknowledged in the cycle they are requested, even while a transfer runs. A window access made while a transfer runs waits until the sequencer is idle.
- R12: After reset, the control and window-select registers read 0, the timing register (offset 0xA8) reads 0x00400295, and WE#/RE# are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Access acknowledge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| nf_ale | output | 1 | Address latch enable |
| nf_cle | output | 1 | Command latch enable |
| nf_cs | output | 2 | Chip-select pins, polarity per control bit 4 |
| nf_se | output | 1 | Spare-area select pin |
| nf_wp | output | 1 | Write-protect pin |
| nf_pre | output | 1 | Precharge pin |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb | input | 2 | Ready/busy inputs, high when ready |

## Verification
A sequencer stuck in a wrong state shows up within one access. The completion flag would stay low on a status poll, a strobe would measure the wrong number of cycles, or a read would never be acknowledged. A wrong phase counter load changes the measured WE#/RE#, chip-select or precharge cycle counts of the very transfer it affects. A wrong decode of the control or window-select bits changes which pins move on the next window access. Polarity errors are visible on the idle pins right after the register write.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOV,
        ST_RDACK
    } nwb_state_t;

    typedef struct packed {
        logic wp;
        logic se;
        logic cs;
        logic cle;
        logic ale;
    } nwb_lines_t;

    typedef struct packed {
        logic       setup;
        logic [1:0] wwait;
        logic [1:0] rwait;
        logic [1:0] hold;
        logic [1:0] recov;
        logic [1:0] mult;
    } nwb_timing_t;

    typedef struct packed {
        logic ce;
        logic out_cs1;
        logic rb_cs1;
        logic pol_pre;
        logic pol_wp;
        logic pol_se;
        logic pol_cs;
        logic cs_mux;
        logic nand_en;
    } nwb_ctrl_t;

    localparam logic [7:0]  OFS_WINSEL = 8'h24;
    localparam logic [7:0]  OFS_TIMING = 8'hA8;
    localparam logic [7:0]  OFS_CTRL   = 8'hB0;
    localparam logic [7:0]  OFS_STATUS = 8'hB4;
    localparam logic [31:0] TIMING_RST = 32'h0040_0295;

    function automatic nwb_timing_t word_to_timing(input logic [31:0] w);
        nwb_timing_t t;
        t.setup = w[22];
        t.wwait = w[9:8];
        t.rwait = w[7:6];
        t.hold  = w[5:4];
        t.recov = w[3:2];
        t.mult  = w[1:0];
        return t;
    endfunction

    function automatic logic [4:0] unit_cycles(input logic [1:0] m);
        case (m)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/nwb_regs.sv
module nwb_regs
    import nwb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int WIN_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              done_i,
    input  logic              rb_i,
    output logic              reg_hit,
    output logic              win_hit,
    output logic [31:0]       reg_rdata,
    output nwb_ctrl_t         ctrl,
    output nwb_timing_t       tim
);
    localparam int BASE_W = ADDR_W - WIN_LSB;

    logic [BASE_W-1:0] base_q;
    logic [3:0]        mask_q;
    logic              win_en_q;
    logic [BASE_W-1:0] bit_ok;
    logic              wr_reg;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;
    assign reg_hit = (addr[ADDR_W-1:8] == '0);
    assign wr_reg  = req && we && reg_hit;

    for (genvar i = WIN_LSB; i < ADDR_W; i++) begin : g_cmp
        assign bit_ok[i-WIN_LSB] = ({28'd0, mask_q} > 32'(i - WIN_LSB)) ||
                                   (addr[i] == base_q[i-WIN_LSB]);
    end

    assign win_hit = win_en_q && (&bit_ok) && !reg_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            mask_q   <= '0;
            win_en_q <= 1'b0;
            ctrl     <= '0;
            tim      <= word_to_timing(TIMING_RST);
        end else if (wr_reg) begin
            unique case (addr[7:0])
                OFS_WINSEL: begin
                    base_q   <= wdata[ADDR_W-1:WIN_LSB];
                    mask_q   <= wdata[7:4];
                    win_en_q <= wdata[0];
                end
                OFS_CTRL: begin
                    ctrl.nand_en <= wdata[0];
                    ctrl.cs_mux  <= wdata[1];
                    ctrl.pol_cs  <= wdata[4];
                    ctrl.pol_se  <= wdata[5];
                    ctrl.pol_wp  <= wdata[6];
                    ctrl.pol_pre <= wdata[7];
                    ctrl.rb_cs1  <= wdata[8];
                    ctrl.out_cs1 <= wdata[10];
                    ctrl.ce      <= wdata[20];
                end
                OFS_TIMING: tim <= word_to_timing(wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr[7:0])
            OFS_WINSEL: begin
                reg_rdata[ADDR_W-1:WIN_LSB] = base_q;
                reg_rdata[7:4]              = mask_q;
                reg_rdata[0]                = win_en_q;
            end
            OFS_CTRL: begin
                reg_rdata[0]  = ctrl.nand_en;
                reg_rdata[1]  = ctrl.cs_mux;
                reg_rdata[4]  = ctrl.pol_cs;
                reg_rdata[5]  = ctrl.pol_se;
                reg_rdata[6]  = ctrl.pol_wp;
                reg_rdata[7]  = ctrl.pol_pre;
                reg_rdata[8]  = ctrl.rb_cs1;
                reg_rdata[10] = ctrl.out_cs1;
                reg_rdata[20] = ctrl.ce;
            end
            OFS_TIMING: begin
                reg_rdata[22]  = tim.setup;
                reg_rdata[9:8] = tim.wwait;
                reg_rdata[7:6] = tim.rwait;
                reg_rdata[5:4] = tim.hold;
                reg_rdata[3:2] = tim.recov;
                reg_rdata[1:0] = tim.mult;
            end
            OFS_STATUS: begin
                reg_rdata[0] = rb_i;
                reg_rdata[3] = done_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nwb_seq.sv
module nwb_seq
    import nwb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_we,
    input  nwb_lines_t  start_lines,
    input  logic [7:0]  start_byte,
    input  nwb_timing_t tim,
    input  logic [7:0]  rd_byte_i,
    output nwb_state_t  state,
    output logic        idle,
    output logic        done,
    output nwb_lines_t  lines_act,
    output logic        we_act,
    output logic        re_act,
    output logic        pre_act,
    output logic        dq_oe,
    output logic [7:0]  dq_o,
    output logic [7:0]  rd_byte
);
    nwb_state_t        nxt;
    logic [CNT_W-1:0]  cnt;
    logic              acc_we;
    nwb_lines_t        acc_lines;
    logic [7:0]        acc_byte;
    nwb_timing_t       acc_tim;
    nwb_timing_t       tsel;
    logic              wsel;
    logic              finish;
    nwb_state_t        after_strobe;
    nwb_state_t        after_hold;
    nwb_state_t        fin_state;

    function automatic logic [CNT_W-1:0] phase_len(input nwb_state_t ph,
                                                    input nwb_timing_t t,
                                                    input logic w);
        logic [CNT_W-1:0] u;
        logic [CNT_W-1:0] k;
        u = CNT_W'(unit_cycles(t.mult));
        k = CNT_W'(w ? t.wwait : t.rwait);
        if (k == '0) k = CNT_W'(1);
        case (ph)
            ST_SETUP:  return u;
            ST_STROBE: return k * u;
            ST_HOLD:   return CNT_W'(t.hold) * u;
            ST_RECOV:  return CNT_W'(t.recov) * u;
            default:   return CNT_W'(1);
        endcase
    endfunction

    assign tsel = (state == ST_IDLE) ? tim : acc_tim;
    assign wsel = (state == ST_IDLE) ? start_we : acc_we;

    assign fin_state    = acc_we ? ST_IDLE : ST_RDACK;
    assign after_hold   = (acc_tim.recov != 2'd0) ? ST_RECOV : fin_state;
    assign after_strobe = (acc_tim.hold != 2'd0) ? ST_HOLD : after_hold;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = tim.setup ? ST_SETUP : ST_STROBE;
            ST_SETUP:  if (cnt == '0) nxt = ST_STROBE;
            ST_STROBE: if (cnt == '0) nxt = after_strobe;
            ST_HOLD:   if (cnt == '0) nxt = after_hold;
            ST_RECOV:  if (cnt == '0) nxt = fin_state;
            ST_RDACK:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign finish = (state inside {ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOV}) &&
                    (nxt inside {ST_IDLE, ST_RDACK});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            done      <= 1'b1;
            acc_we    <= 1'b0;
            acc_lines <= '0;
            acc_byte  <= '0;
            acc_tim   <= '0;
            rd_byte   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt <= phase_len(nxt, tsel, wsel) - CNT_W'(1);
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end
            if (state == ST_IDLE && start) begin
                acc_we    <= start_we;
                acc_lines <= start_lines;
                acc_byte  <= start_byte;
                acc_tim   <= tim;
                done      <= 1'b0;
            end else if (finish) begin
                done <= 1'b1;
            end
            if (state == ST_STROBE && cnt == '0 && !acc_we) begin
                rd_byte <= rd_byte_i;
            end
        end
    end

    always_comb begin
        idle      = (state == ST_IDLE);
        lines_act = (state inside {ST_SETUP, ST_STROBE, ST_HOLD}) ? acc_lines : '0;
        we_act    = (state == ST_STROBE) && acc_we;
        re_act    = (state == ST_STROBE) && !acc_we;
        pre_act   = (state == ST_RECOV);
        dq_oe     = we_act;
        dq_o      = acc_byte;
    end

    // checker-side strobe width measurement
    logic [CNT_W-1:0] chk_run;
    logic [CNT_W-1:0] chk_exp;
    logic [1:0]       chk_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 chk_run <= '0;
        else if (state == ST_STROBE) chk_run <= chk_run + CNT_W'(1);
        else                        chk_run <= '0;
    end

    assign chk_w   = acc_we ? acc_tim.wwait : acc_tim.rwait;
    assign chk_exp = CNT_W'((chk_w == 2'd0) ? 2'd1 : chk_w) << (acc_tim.mult == 2'd0 ? 0 : acc_tim.mult + 2'd1);

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_STROBE && state != ST_STROBE) |-> (chk_run == chk_exp)); // R6

    AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOV}) |-> !done); // R8

    AST_RDACK_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RDACK) |-> ($past(state) inside {ST_STROBE, ST_HOLD, ST_RECOV})); // R10

    AST_DONE_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (finish) |=> done); // R8

endmodule

// File: rtl/nand_window_bridge.sv
module nand_window_bridge
    import nwb_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int WIN_LSB = 12,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ack,
    output logic [31:0]       cpu_rdata,
    output logic              nf_ale,
    output logic              nf_cle,
    output logic [1:0]        nf_cs,
    output logic              nf_se,
    output logic              nf_wp,
    output logic              nf_pre,
    output logic              nf_we_n,
    output logic              nf_re_n,
    output logic [7:0]        nf_dq_o,
    output logic              nf_dq_oe,
    input  logic [7:0]        nf_dq_i,
    input  logic [1:0]        nf_rb
);
    nwb_ctrl_t   ctrl;
    nwb_timing_t tim;
    nwb_state_t  state;
    nwb_lines_t  start_lines;
    nwb_lines_t  lines_act;
    logic        reg_hit, win_hit, win_acc, start;
    logic        seq_idle, seq_done, rd_ack;
    logic        we_act, re_act, pre_act, cs_act;
    logic [31:0] reg_rdata;
    logic [7:0]  rd_byte;
    logic        rb_sel;

    assign rb_sel = ctrl.rb_cs1 ? nf_rb[1] : nf_rb[0];

    nwb_regs #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .addr(cpu_addr),
        .wdata(cpu_wdata), .done_i(seq_done), .rb_i(rb_sel),
        .reg_hit(reg_hit), .win_hit(win_hit), .reg_rdata(reg_rdata),
        .ctrl(ctrl), .tim(tim)
    );

    assign win_acc = cpu_req && win_hit && ctrl.nand_en;
    assign start   = win_acc && seq_idle;
    assign rd_ack  = (state == ST_RDACK);

    always_comb begin
        start_lines.ale = cpu_addr[2];
        start_lines.cle = cpu_addr[3];
        start_lines.cs  = cpu_addr[4] || !ctrl.cs_mux;
        start_lines.se  = cpu_addr[5];
        start_lines.wp  = cpu_addr[6];
    end

    nwb_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_we(cpu_we),
        .start_lines(start_lines), .start_byte(cpu_wdata[7:0]), .tim(tim),
        .rd_byte_i(nf_dq_i), .state(state), .idle(seq_idle), .done(seq_done),
        .lines_act(lines_act), .we_act(we_act), .re_act(re_act), .pre_act(pre_act),
        .dq_oe(nf_dq_oe), .dq_o(nf_dq_o), .rd_byte(rd_byte)
    );

    always_comb begin
        cpu_ack = rd_ack || (cpu_req && (!win_acc || (cpu_we && seq_idle)));
        if (reg_hit)     cpu_rdata = reg_rdata;
        else if (rd_ack) cpu_rdata = {24'd0, rd_byte};
        else             cpu_rdata = '0;
    end

    assign cs_act   = lines_act.cs && ctrl.ce;
    assign nf_ale   = lines_act.ale;
    assign nf_cle   = lines_act.cle;
    assign nf_cs[0] = (cs_act && !ctrl.out_cs1) ^ ctrl.pol_cs;
    assign nf_cs[1] = (cs_act && ctrl.out_cs1) ^ ctrl.pol_cs;
    assign nf_se    = lines_act.se ^ ctrl.pol_se;
    assign nf_wp    = lines_act.wp ^ ctrl.pol_wp;
    assign nf_pre   = pre_act ^ ctrl.pol_pre;
    assign nf_we_n  = !we_act;
    assign nf_re_n  = !re_act;

    AST_MISS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !reg_hit && !(win_hit && ctrl.nand_en) && seq_idle) |=> seq_idle); // R1

    AST_REG_ACK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && reg_hit) |-> cpu_ack); // R11

    AST_CE_GATES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.ce |-> (nf_cs == {2{ctrl.pol_cs}})); // R5

    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        nf_dq_oe |-> (nf_re_n && !nf_we_n)); // R9

endmodule

// File: tb/nand_window_bridge_tb.sv
module nand_window_bridge_tb;

    typedef struct {
        bit       wr;
        int       width;
        int       cs_cyc;
        int       pre_cyc;
        bit [3:0] lines;
        bit [1:0] cs_pin;
        bit [7:0] dq;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cpu_req = 0, cpu_we = 0;
    logic [23:0] cpu_addr = 0;
    logic [31:0] cpu_wdata = 0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        nf_ale, nf_cle, nf_se, nf_wp, nf_pre, nf_we_n, nf_re_n, nf_dq_oe;
    logic [1:0]  nf_cs;
    logic [7:0]  nf_dq_o;
    logic [7:0]  nf_dq_i = 0;
    logic [1:0]  nf_rb = 2'b01;

    int nchk = 0, nerr = 0, pushed = 0, mon_items = 0;
    logic [31:0] sh_ctrl = 0;
    logic [31:0] sh_tim  = 32'h0040_0295;
    item_t exp_q[$];

    always #4 clk = ~clk;

    nand_window_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .nf_ale(nf_ale), .nf_cle(nf_cle), .nf_cs(nf_cs),
        .nf_se(nf_se), .nf_wp(nf_wp), .nf_pre(nf_pre), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
        .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: measures each burst of flash activity and pops the scoreboard
    bit m_on = 0, m_oebad = 0, m_wr = 0;
    int m_w = 0, m_cs = 0, m_pre = 0;
    bit [3:0] m_lines;
    bit [1:0] m_cspin;
    bit [7:0] m_dq;

    always @(negedge clk) begin
        logic [1:0] cs_l;
        logic se_l, wp_l, pre_l, act;
        cs_l  = nf_cs ^ {2{sh_ctrl[4]}};
        se_l  = nf_se ^ sh_ctrl[5];
        wp_l  = nf_wp ^ sh_ctrl[6];
        pre_l = nf_pre ^ sh_ctrl[7];
        act   = nf_ale | nf_cle | (|cs_l) | se_l | wp_l | pre_l | !nf_we_n | !nf_re_n;
        if (rst_n && act) begin
            if (!m_on) begin
                m_on = 1; m_w = 0; m_cs = 0; m_pre = 0; m_oebad = 0; m_wr = 0;
            end
            if (!nf_we_n || !nf_re_n) begin
                if (m_w == 0) begin
                    m_lines = {wp_l, se_l, nf_cle, nf_ale};
                    m_cspin = cs_l;
                    m_dq    = nf_dq_o;
                end
                m_w++;
                if (!nf_we_n) m_wr = 1;
            end
            if (|cs_l) m_cs++;
            if (pre_l) m_pre++;
            if (nf_dq_oe != !nf_we_n) m_oebad = 1;
        end else if (m_on) begin
            m_on = 0;
            mon_items++;
            if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected flash activity", 1, 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(m_wr == e.wr, "R2 strobe kind", m_wr, e.wr);
                chk(m_w == e.width, "R6 strobe width", m_w, e.width);
                chk(m_cs == e.cs_cyc, "R7 chip-select cycles", m_cs, e.cs_cyc);
                chk(m_pre == e.pre_cyc, "R7 precharge cycles", m_pre, e.pre_cyc);
                chk(m_lines == e.lines, "R2 lines wp/se/cle/ale", m_lines, e.lines);
                chk(m_cspin == e.cs_pin, "R4 chip-select pin", m_cspin, e.cs_pin);
                chk(m_oebad == 0, "R9 output enable window", m_oebad, 0);
                if (e.wr) chk(m_dq == e.dq, "R9 write byte", m_dq, e.dq);
            end
        end else if (rst_n && nf_dq_oe) begin
            chk(0, "R9 oe while idle", 1, 0);
        end
    end

    function automatic item_t mk_item(input bit wr, input logic [23:0] a, input logic [7:0] d);
        item_t it;
        int u, w, su, hd;
        bit cs;
        case (sh_tim[1:0]) 0: u = 1; 1: u = 4; 2: u = 8; default: u = 16; endcase
        w  = wr ? int'(sh_tim[9:8]) : int'(sh_tim[7:6]);
        if (w == 0) w = 1;
        su = sh_tim[22] ? u : 0;
        hd = int'(sh_tim[5:4]) * u;
        cs = sh_ctrl[20] && (a[4] || !sh_ctrl[1]);
        it.wr      = wr;
        it.width   = w * u;
        it.cs_cyc  = cs ? su + w * u + hd : 0;
        it.pre_cyc = int'(sh_tim[3:2]) * u;
        it.lines   = {a[6], a[5], a[3], a[2]};
        it.cs_pin  = sh_ctrl[10] ? {cs, 1'b0} : {1'b0, cs};
        it.dq      = d;
        return it;
    endfunction

    task automatic bus(input bit we, input logic [23:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        waits = 0;
        while (!cpu_ack) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic reg_wr(input logic [7:0] ofs, input logic [31:0] v);
        logic [31:0] rd; int wt;
        bus(1, {16'd0, ofs}, v, rd, wt);
        if (ofs == 8'hB0) sh_ctrl = v;
        if (ofs == 8'hA8) sh_tim = v;
    endtask

    task automatic reg_rd(input logic [7:0] ofs, output logic [31:0] v, output int wt);
        bus(0, {16'd0, ofs}, 0, v, wt);
    endtask

    task automatic win_wr(input logic [23:0] a, input logic [7:0] d, input bit expect_act, output int wt);
        logic [31:0] rd;
        if (expect_act) begin exp_q.push_back(mk_item(1, a, d)); pushed++; end
        bus(1, a, {24'd0, d}, rd, wt);
    endtask

    task automatic win_rd(input logic [23:0] a, input bit expect_act, output logic [31:0] v);
        int wt;
        if (expect_act) begin exp_q.push_back(mk_item(0, a, 8'h00)); pushed++; end
        bus(0, a, 0, v, wt);
    endtask

    task automatic wait_done();
        logic [31:0] v; int wt;
        for (int i = 0; i < 300; i++) begin
            reg_rd(8'hB4, v, wt);
            if (v[3]) break;
        end
        chk(v[3] == 1, "R8 completion flag sets", v[3], 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        nerr++;
        nchk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wt, n0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(nf_we_n && nf_re_n && !nf_dq_oe, "R12 strobes idle", {nf_we_n, nf_re_n, nf_dq_oe}, 3'b110);
        chk(nf_cs == 2'b00 && !nf_pre && !nf_se && !nf_wp, "R3 idle pins active-high", {nf_cs, nf_pre, nf_se, nf_wp}, 0);
        reg_rd(8'hB4, v, wt); chk(v == 32'h9, "R8 status after reset", v, 32'h9);
        reg_rd(8'hB0, v, wt); chk(v == 0, "R12 control reset", v, 0);
        reg_rd(8'hA8, v, wt); chk(v == 32'h0040_0295, "R12 timing reset", v, 32'h0040_0295);
        reg_rd(8'h24, v, wt); chk(v == 0, "R12 window reset", v, 0);

        // R1 window disabled: ignored
        n0 = mon_items;
        win_wr(24'h001018, 8'hFF, 0, wt);
        chk(wt == 0, "R1 ignored access acked at once", wt, 0);
        win_rd(24'h001010, 0, v);
        chk(v == 0, "R1 ignored read data", v, 0);
        repeat (30) @(negedge clk);
        chk(mon_items == n0, "R1 no activity when disabled", mon_items, n0);

        reg_wr(8'h24, 32'h0000_1001);
        reg_rd(8'h24, v, wt); chk(v == 32'h1001, "R1 window register", v, 32'h1001);
        reg_wr(8'hB0, 32'h0010_0003);
        win_wr(24'h002018, 8'h77, 0, wt);
        repeat (30) @(negedge clk);
        chk(mon_items == n0, "R1 outside window ignored", mon_items, n0);

        // command, address, data
        win_wr(24'h001018, 8'hFF, 1, wt);
        reg_rd(8'hB4, v, wt);
        chk(v[3] == 0, "R8 flag clears on start", v[3], 0);
        chk(wt == 0, "R11 register ack while busy", wt, 0);
        wait_done();
        win_wr(24'h001014, 8'h00, 1, wt); wait_done();
        win_wr(24'h001010, 8'hA5, 1, wt); wait_done();

        // read
        nf_dq_i = 8'h3C;
        win_rd(24'h001010, 1, v);
        chk(v == 32'h3C, "R10 read byte returned", v, 32'h3C);
        reg_rd(8'hB4, v, wt); chk(v[3] == 1, "R8 flag after read", v[3], 1);

        // stall
        win_wr(24'h001010, 8'h11, 1, wt);
        win_wr(24'h001010, 8'h22, 1, wt);
        chk(wt > 10, "R11 window access stalls while busy", wt, 11);
        wait_done();

        // minimal timing
        reg_wr(8'hA8, 32'h0000_0300);
        win_wr(24'h001018, 8'h90, 1, wt); wait_done();
        nf_dq_i = 8'hC3;
        win_rd(24'h001010, 1, v);
        chk(v == 32'hC3, "R10 read with short timing", v, 32'hC3);

        // mult 8 timing
        reg_wr(8'hA8, 32'h0040_01E6);
        win_wr(24'h001014, 8'h5E, 1, wt); wait_done();
        nf_dq_i = 8'h81;
        win_rd(24'h001010, 1, v);
        chk(v == 32'h81, "R10 read with long strobe", v, 32'h81);
        reg_wr(8'hA8, 32'h0040_0295);

        // polarity
        reg_wr(8'hB0, 32'h0010_00F3);
        @(negedge clk);
        chk({nf_cs, nf_se, nf_wp, nf_pre} == 5'b11111, "R3 inverted idle pins", {nf_cs, nf_se, nf_wp, nf_pre}, 5'b11111);
        win_wr(24'h001070, 8'h3A, 1, wt); wait_done();

        // routing
        reg_wr(8'hB0, 32'h0010_05F3);
        win_wr(24'h001010, 8'h44, 1, wt); wait_done();
        nf_rb = 2'b10;
        reg_rd(8'hB4, v, wt); chk(v[0] == 1, "R4 ready from input 1", v[0], 1);
        reg_wr(8'hB0, 32'h0010_04F3);
        reg_rd(8'hB4, v, wt); chk(v[0] == 0, "R4 ready from input 0", v[0], 0);
        nf_rb = 2'b01;

        // mode bits
        reg_wr(8'hB0, 32'h0010_0001);
        win_wr(24'h001000, 8'h12, 1, wt); wait_done();
        reg_wr(8'hB0, 32'h0000_0003);
        win_wr(24'h001018, 8'h34, 1, wt); wait_done();
        reg_wr(8'hB0, 32'h0010_0002);
        n0 = mon_items;
        win_wr(24'h001010, 8'h56, 0, wt);
        win_rd(24'h001010, 0, v);
        chk(v == 0, "R5 read ignored without NAND mode", v, 0);
        repeat (40) @(negedge clk);
        chk(mon_items == n0, "R5 no activity without NAND mode", mon_items, n0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && mon_items == pushed, "R2 all transfers observed", mon_items, pushed);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule